// File: doc/BRIEF.md
# Ethernet PHY Management Register Slave

This block is the management slave of an Ethernet PHY. It runs on the management clock. It listens to a serial management line through separate input, output and output-enable ports, so the pad logic can build the bidirectional pin. It decodes read and write frames addressed either to the PHY address set on five strap inputs or to address zero.

The slave holds a control register at address 0 and a status register at address 1. The control register carries a self-clearing soft-reset bit, a power-down bit and an isolate bit. These bits are combined with matching pins to drive the chip's power-down and isolate controls. A reset sequencer drives a chip-wide reset for a fixed number of cycles. It starts after power-on reset, after the active-low reset pin, after a soft-reset write, and when the chip leaves power-down. Management reads and writes keep working while the chip is isolated or powered down.

The frame is a preamble of at least 32 ones, then start bits `01`, a 2-bit opcode (`10` read, `01` write), a 5-bit PHY address, a 5-bit register address and two turnaround bits. It ends with 16 data bits, MSB first. Every bit is sampled on the rising edge of the management clock.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: A frame is accepted when its PHY address field equals `phy_addr_strap` or is 0. For any other address, `mdio_oe` stays 0 for the whole frame and a write changes no register.
- R2: On an accepted read, `mdio_oe` stays 0 during the first turnaround bit. The block drives 0 during the second turnaround bit. It then drives the 16 data bits MSB first, each updated on the rising edge. It releases `mdio_oe` after the last data bit.
- R3: Register 0 bit 11 (power-down) and bit 10 (isolate) take the written values and read back. All other register 0 bits read 0, except bit 15 while the reset sequence runs.
- R4: `pwrdn_o` is register 0 bit 11 OR `pwrdn_pin`, registered one cycle.
- R5: `isolate_o` is register 0 bit 10 OR `iso_pin`, registered one cycle. On `por` or the reset pin, bit 10 loads the value of `iso_default_strap`.
- R6: Register 1 reads `aneg_strap` at bit 3 and 0 at every other bit. Writes to register 1 are ignored.
- R7: Writing 1 to register 0 bit 15 holds `chip_reset_o` high for exactly RST_CYCLES cycles. Bit 15 reads 1 until that window ends and 0 afterwards. Writing 0 to bit 15 has no effect.
- R8: `chip_reset_o` is also raised by `por`, by `rst_pin_n` low (held low plus RST_CYCLES-1 further cycles after release), and by `pwrdn_o` falling. The pin reset restores the register 0 defaults.
- R9: Reads of register addresses other than 0 and 1 return 0. Writes to them change nothing.
- R10: A frame with start bits other than `01`, or an opcode other than `10` or `01`, is dropped. No further frame is decoded until a fresh preamble of 32 ones arrives.
- R11: Reads and writes complete normally while `isolate_o` or `pwrdn_o` is high.
- R12: A soft-reset write that lands in the last cycle of a running reset window restarts a full window. Bit 15 stays 1 and `chip_reset_o` does not drop in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock |
| por | input | 1 | Synchronous active-high power-on reset |
| rst_pin_n | input | 1 | Active-low hardware reset pin |
| phy_addr_strap | input | 5 | Strapped PHY address |
| iso_default_strap | input | 1 | Reset value of the isolate bit |
| iso_pin | input | 1 | Forces isolation when high |
| pwrdn_pin | input | 1 | Forces power-down when high |
| aneg_strap | input | 1 | Auto-negotiation ability, shown in register 1 bit 3 |
| mdio_i | input | 1 | Management data in |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Output enable for the management data pin |
| chip_reset_o | output | 1 | Chip-wide reset from the sequencer |
| pwrdn_o | output | 1 | Power-down control |
| isolate_o | output | 1 | Isolate control |

## Verification
The reset window's end and a new soft-reset write can reach the sequencer in the same cycle. In that cycle the self-clear of bit 15 and the write's setting of it compete. The bench provokes this by sending two soft-reset write frames back to back. With the default RST_CYCLES of 64, the second commit falls exactly on the final count of the first window. A negedge monitor measures the length of each high run of `chip_reset_o`; one unbroken run of 128 cycles means the write won and the window restarted. Leaving power-down through a register write is also checked: the new window must start from the falling power-down output.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int AW = 5;   // PHY and register address width
  localparam int DW = 16;  // register data width
  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [AW-1:0] RA_CTRL = 5'd0;
  localparam logic [AW-1:0] RA_STAT = 5'd1;
  localparam int B_SRST = 15;
  localparam int B_PDN  = 11;
  localparam int B_ISO  = 10;
  localparam int B_ANEG = 3;
  typedef enum logic [2:0] {F_IDLE, F_START, F_HDR, F_TA, F_DATA} fstate_e;
endpackage

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mdio_i,
  input  logic [AW-1:0] phy_strap,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] reg_addr,
  output logic          wr_en,
  output logic [DW-1:0] wr_data,
  output logic          mdio_o,
  output logic          mdio_oe
);
  localparam int HDR_BITS = 2 + 2 * AW;
  localparam int MAXB     = (DW > HDR_BITS) ? DW : HDR_BITS;
  localparam int CW       = $clog2(MAXB) + 1;
  localparam int PW       = $clog2(PRE_LEN + 1);

  fstate_e               state;
  logic [PW-1:0]         pre_cnt;
  logic [CW-1:0]         cnt;
  logic [HDR_BITS-2:0]   hdr;
  logic [HDR_BITS-1:0]   hdr_full;
  logic [DW-1:0]         sh;
  logic                  is_rd, hit_q;
  logic [1:0]            op;
  logic [AW-1:0]         phy_fld;

  assign hdr_full = {hdr, mdio_i};
  assign op       = hdr_full[HDR_BITS-1 -: 2];
  assign phy_fld  = hdr_full[2*AW-1:AW];

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= F_IDLE;
      pre_cnt  <= '0;
      cnt      <= '0;
      hdr      <= '0;
      sh       <= '0;
      is_rd    <= 1'b0;
      hit_q    <= 1'b0;
      reg_addr <= '0;
      wr_en    <= 1'b0;
      wr_data  <= '0;
      mdio_o   <= 1'b0;
      mdio_oe  <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      case (state)
        F_IDLE: begin
          if (mdio_i) begin
            if (pre_cnt != PW'(PRE_LEN)) pre_cnt <= pre_cnt + 1'b1;
          end else begin
            if (pre_cnt == PW'(PRE_LEN)) state <= F_START;
            pre_cnt <= '0;
          end
        end
        F_START: begin
          state <= mdio_i ? F_HDR : F_IDLE;
          cnt   <= '0;
        end
        F_HDR: begin
          hdr <= hdr_full[HDR_BITS-2:0];
          cnt <= cnt + 1'b1;
          if (cnt == CW'(HDR_BITS - 1)) begin
            cnt <= '0;
            if (op == OP_RD || op == OP_WR) begin
              state    <= F_TA;
              is_rd    <= (op == OP_RD);
              hit_q    <= (phy_fld == phy_strap) || (phy_fld == '0);
              reg_addr <= hdr_full[AW-1:0];
            end else begin
              state <= F_IDLE;
            end
          end
        end
        F_TA: begin
          cnt <= cnt + 1'b1;
          if (cnt == '0) begin
            sh <= rd_data;
            if (is_rd && hit_q) begin
              mdio_oe <= 1'b1;
              mdio_o  <= 1'b0;
            end
          end else begin
            state <= F_DATA;
            cnt   <= '0;
            if (is_rd && hit_q) begin
              mdio_o <= sh[DW-1];
              sh     <= {sh[DW-2:0], 1'b0};
            end
          end
        end
        F_DATA: begin
          cnt <= cnt + 1'b1;
          if (is_rd) begin
            mdio_o <= sh[DW-1];
            sh     <= {sh[DW-2:0], 1'b0};
          end else begin
            sh <= {sh[DW-2:0], mdio_i};
          end
          if (cnt == CW'(DW - 1)) begin
            state   <= F_IDLE;
            mdio_oe <= 1'b0;
            mdio_o  <= 1'b0;
            if (!is_rd && hit_q) begin
              wr_en   <= 1'b1;
              wr_data <= {sh[DW-2:0], mdio_i};
            end
          end
        end
        default: state <= F_IDLE;
      endcase
    end
  end

  // R2: the first driven turnaround bit is a zero
  a_r2_ta_low: assert property (@(posedge clk) disable iff (rst)
    $rose(mdio_oe) |-> !mdio_o);
  // R1: the line is driven only for an accepted read
  a_r1_drive_needs_hit: assert property (@(posedge clk) disable iff (rst)
    mdio_oe |-> (hit_q && is_rd));
  // R10: nothing is driven while hunting for a preamble
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (state == F_IDLE) |-> !mdio_oe);
endmodule

// File: rtl/mgmt_regs.sv
module mgmt_regs
  import mdio_pkg::*;
(
  input  logic          clk,
  input  logic          por,
  input  logic          pin_rst,
  input  logic          wr_en,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic          iso_def,
  input  logic          iso_pin,
  input  logic          pd_pin,
  input  logic          aneg,
  input  logic          seq_done,
  output logic          soft_req,
  output logic          pd_exit,
  output logic          pwrdn_o,
  output logic          isolate_o
);
  logic sr_q, pd_q, iso_q;
  logic ctrl_wr;
  logic unused_wr_bits;

  assign ctrl_wr  = wr_en && (reg_addr == RA_CTRL);
  assign soft_req = ctrl_wr && wr_data[B_SRST];
  assign pd_exit  = pwrdn_o && !(pd_q || pd_pin);
  assign unused_wr_bits = ^{wr_data[14:12], wr_data[9:0]};

  always_ff @(posedge clk) begin
    if (por || pin_rst) begin
      sr_q  <= 1'b0;
      pd_q  <= 1'b0;
      iso_q <= iso_def;
    end else begin
      if (seq_done) sr_q <= 1'b0;
      if (ctrl_wr) begin
        if (wr_data[B_SRST]) sr_q <= 1'b1;  // write beats self-clear
        pd_q  <= wr_data[B_PDN];
        iso_q <= wr_data[B_ISO];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (por) begin
      pwrdn_o   <= 1'b0;
      isolate_o <= 1'b0;
    end else begin
      pwrdn_o   <= pd_q || pd_pin;
      isolate_o <= iso_q || iso_pin;
    end
  end

  always_comb begin
    rd_data = '0;
    if (reg_addr == RA_CTRL) begin
      rd_data[B_SRST] = sr_q;
      rd_data[B_PDN]  = pd_q;
      rd_data[B_ISO]  = iso_q;
    end else if (reg_addr == RA_STAT) begin
      rd_data[B_ANEG] = aneg;
    end
  end

  a_r4_pd_pin: assert property (@(posedge clk) disable iff (por)
    pd_pin |=> pwrdn_o);
  a_r5_iso_pin: assert property (@(posedge clk) disable iff (por)
    iso_pin |=> isolate_o);
  a_r7_sr_set: assert property (@(posedge clk) disable iff (por || pin_rst)
    (soft_req && !por && !pin_rst) |=> sr_q);
endmodule

// File: rtl/reset_seq.sv
module reset_seq #(
  parameter int RST_CYCLES = 64
) (
  input  logic clk,
  input  logic por,
  input  logic hard,
  input  logic soft_req,
  input  logic pd_exit,
  output logic busy,
  output logic done
);
  localparam int CNTW = $clog2(RST_CYCLES + 1);
  logic [CNTW-1:0] cnt;
  logic            load;

  assign load = soft_req || pd_exit;
  assign busy = (cnt != '0);
  assign done = (cnt == CNTW'(1));

  always_ff @(posedge clk) begin
    if (por || hard)  cnt <= CNTW'(RST_CYCLES);
    else if (load)    cnt <= CNTW'(RST_CYCLES);
    else if (busy)    cnt <= cnt - 1'b1;
  end

  a_r8_hard: assert property (@(posedge clk) disable iff (por)
    hard |=> busy);
  a_r12_restart: assert property (@(posedge clk) disable iff (por || hard)
    (load && done) |=> (cnt == CNTW'(RST_CYCLES)));
endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave
  import mdio_pkg::*;
#(
  parameter int PRE_LEN    = 32,
  parameter int RST_CYCLES = 64
) (
  input  logic          mdc,
  input  logic          por,
  input  logic          rst_pin_n,
  input  logic [AW-1:0] phy_addr_strap,
  input  logic          iso_default_strap,
  input  logic          iso_pin,
  input  logic          pwrdn_pin,
  input  logic          aneg_strap,
  input  logic          mdio_i,
  output logic          mdio_o,
  output logic          mdio_oe,
  output logic          chip_reset_o,
  output logic          pwrdn_o,
  output logic          isolate_o
);
  logic [AW-1:0] reg_addr;
  logic [DW-1:0] rd_data, wr_data;
  logic          wr_en, soft_req, pd_exit, seq_done;

  mdio_frame #(.PRE_LEN(PRE_LEN)) u_frame (
    .clk(mdc), .rst(por), .mdio_i(mdio_i), .phy_strap(phy_addr_strap),
    .rd_data(rd_data), .reg_addr(reg_addr), .wr_en(wr_en), .wr_data(wr_data),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  mgmt_regs u_regs (
    .clk(mdc), .por(por), .pin_rst(!rst_pin_n), .wr_en(wr_en),
    .reg_addr(reg_addr), .wr_data(wr_data), .rd_data(rd_data),
    .iso_def(iso_default_strap), .iso_pin(iso_pin), .pd_pin(pwrdn_pin),
    .aneg(aneg_strap), .seq_done(seq_done), .soft_req(soft_req),
    .pd_exit(pd_exit), .pwrdn_o(pwrdn_o), .isolate_o(isolate_o)
  );

  reset_seq #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk(mdc), .por(por), .hard(!rst_pin_n), .soft_req(soft_req),
    .pd_exit(pd_exit), .busy(chip_reset_o), .done(seq_done)
  );
endmodule

// File: tb/mdio_mgmt_slave_tb.sv
module mdio_mgmt_slave_tb;
  localparam int RST = 64;
  localparam logic [4:0] STRAP = 5'h0B;

  logic mdc = 1'b0;
  logic por, rst_pin_n, iso_default_strap, iso_pin, pwrdn_pin, aneg_strap, mdio_i;
  logic [4:0] phy_addr_strap;
  logic mdio_o, mdio_oe, chip_reset_o, pwrdn_o, isolate_o;
  int checks = 0, failures = 0;
  int hi_run = 0, last_run = 0;
  bit finished = 0;

  always #5 mdc = ~mdc;

  mdio_mgmt_slave #(.PRE_LEN(32), .RST_CYCLES(RST)) u_dut (
    .mdc(mdc), .por(por), .rst_pin_n(rst_pin_n), .phy_addr_strap(phy_addr_strap),
    .iso_default_strap(iso_default_strap), .iso_pin(iso_pin), .pwrdn_pin(pwrdn_pin),
    .aneg_strap(aneg_strap), .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .chip_reset_o(chip_reset_o), .pwrdn_o(pwrdn_o), .isolate_o(isolate_o)
  );

  always @(negedge mdc) begin
    if (chip_reset_o) hi_run++;
    else begin
      if (hi_run != 0) last_run = hi_run;
      hi_run = 0;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_bit(input logic b);
    @(negedge mdc);
    mdio_i = b;
  endtask

  task automatic send_hdr(input logic [1:0] st, input logic [1:0] op,
                          input logic [4:0] pa, input logic [4:0] ra);
    for (int i = 0; i < 32; i++) set_bit(1'b1);
    for (int i = 1; i >= 0; i--) set_bit(st[i]);
    for (int i = 1; i >= 0; i--) set_bit(op[i]);
    for (int i = 4; i >= 0; i--) set_bit(pa[i]);
    for (int i = 4; i >= 0; i--) set_bit(ra[i]);
  endtask

  task automatic frame_wr(input logic [1:0] st, input logic [1:0] op,
                          input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] d);
    send_hdr(st, op, pa, ra);
    set_bit(1'b1);
    set_bit(1'b0);
    for (int i = 15; i >= 0; i--) set_bit(d[i]);
    set_bit(1'b1);
  endtask

  task automatic mgmt_wr(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] d);
    frame_wr(2'b01, 2'b01, pa, ra, d);
  endtask

  // back-to-back variant: leaves the bus right after the last data bit
  task automatic mgmt_wr_tight(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] d);
    send_hdr(2'b01, 2'b01, pa, ra);
    set_bit(1'b1);
    set_bit(1'b0);
    for (int i = 15; i >= 0; i--) set_bit(d[i]);
  endtask

  task automatic mgmt_rd(input logic [4:0] pa, input logic [4:0] ra,
                         output logic [15:0] d, output logic resp, output logic drove);
    send_hdr(2'b01, 2'b10, pa, ra);
    resp = 1'b1; drove = 1'b0; d = '0;
    @(negedge mdc);
    mdio_i = 1'b1;
    if (mdio_oe) begin resp = 1'b0; drove = 1'b1; end
    @(negedge mdc);
    if (mdio_oe) drove = 1'b1;
    if (!mdio_oe || mdio_o) resp = 1'b0;
    for (int i = 15; i >= 0; i--) begin
      @(negedge mdc);
      d[i] = mdio_o;
      if (mdio_oe) drove = 1'b1; else resp = 1'b0;
    end
    @(negedge mdc);
    if (mdio_oe) begin resp = 1'b0; drove = 1'b1; end
  endtask

  task automatic wait_reset_done();
    int guard = 0;
    @(negedge mdc);
    while (chip_reset_o && guard < 1000) begin
      @(negedge mdc);
      guard++;
    end
    @(negedge mdc);
  endtask

  task automatic t_reset();
    logic [15:0] d; logic r, dr;
    check("R8 por raises reset", chip_reset_o, 1);
    repeat (2) @(negedge mdc);
    check("R5 iso default after por", isolate_o, 1);
    check("R4 pwrdn idle after por", pwrdn_o, 0);
    wait_reset_done();
    check("R8 por window length", last_run >= RST, 1);
    mgmt_rd(STRAP, 5'd0, d, r, dr);
    check("R2 read response shape", r, 1);
    check("R5 reg0 default", d, 16'h0400);
    mgmt_rd(STRAP, 5'd1, d, r, dr);
    check("R6 reg1 aneg bit", d, 16'h0008);
  endtask

  task automatic t_addr();
    logic [15:0] d; logic r, dr;
    mgmt_rd(5'd0, 5'd1, d, r, dr);
    check("R1 addr zero responds", r, 1);
    check("R1 addr zero data", d, 16'h0008);
    mgmt_rd(5'h03, 5'd1, d, r, dr);
    check("R1 miss never drives", dr, 0);
    mgmt_wr(5'h03, 5'd0, 16'h0000);
    mgmt_rd(STRAP, 5'd0, d, r, dr);
    check("R1 miss write ignored", d, 16'h0400);
    mgmt_wr(5'd0, 5'd0, 16'h0000);
    mgmt_rd(STRAP, 5'd0, d, r, dr);
    check("R3 iso bit cleared", d, 16'h0000);
    check("R5 isolate follows bit", isolate_o, 0);
  endtask

  task automatic t_pins();
    logic [15:0] d; logic r, dr;
    iso_pin = 1'b1;
    repeat (2) @(negedge mdc);
    check("R5 iso pin forces isolate", isolate_o, 1);
    mgmt_rd(STRAP, 5'd1, d, r, dr);
    check("R11 read while isolated", {r, d}, {1'b1, 16'h0008});
    iso_pin = 1'b0;
    pwrdn_pin = 1'b1;
    repeat (2) @(negedge mdc);
    check("R4 pd pin forces pwrdn", pwrdn_o, 1);
    mgmt_wr(STRAP, 5'd0, 16'h0400);
    mgmt_rd(STRAP, 5'd0, d, r, dr);
    check("R11 write and read while powered down", {r, d}, {1'b1, 16'h0400});
    pwrdn_pin = 1'b0;
    repeat (3) @(negedge mdc);
    check("R8 leaving power-down raises reset", chip_reset_o, 1);
    wait_reset_done();
    check("R8 power-down exit window", last_run, RST);
  endtask

  task automatic t_pd_reg();
    logic [15:0] d; logic r, dr;
    mgmt_wr(STRAP, 5'd0, 16'h0800);
    repeat (3) @(negedge mdc);
    check("R4 pd bit drives pwrdn", pwrdn_o, 1);
    mgmt_rd(STRAP, 5'd0, d, r, dr);
    check("R3 pd bit reads back", d, 16'h0800);
    mgmt_wr(STRAP, 5'd0, 16'h0000);
    repeat (3) @(negedge mdc);
    check("R4 pwrdn released", pwrdn_o, 0);
    check("R8 register pd exit raises reset", chip_reset_o, 1);
    wait_reset_done();
  endtask

  task automatic t_unimpl();
    logic [15:0] d; logic r, dr;
    mgmt_wr(STRAP, 5'd5, 16'hFFFF);
    mgmt_rd(STRAP, 5'd5, d, r, dr);
    check("R9 unimplemented reads zero", {r, d}, {1'b1, 16'h0000});
    mgmt_rd(STRAP, 5'd0, d, r, dr);
    check("R9 unimplemented write leaves reg0", d, 16'h0000);
    check("R9 no reset from stray write", chip_reset_o, 0);
    mgmt_wr(STRAP, 5'd1, 16'hFFFF);
    mgmt_rd(STRAP, 5'd1, d, r, dr);
    check("R6 reg1 write ignored", d, 16'h0008);
  endtask

  task automatic t_bad();
    logic [15:0] d; logic r, dr;
    frame_wr(2'b01, 2'b11, STRAP, 5'd0, 16'h0800);
    repeat (3) @(negedge mdc);
    check("R10 bad opcode no pwrdn", pwrdn_o, 0);
    frame_wr(2'b00, 2'b01, STRAP, 5'd0, 16'h0800);
    repeat (3) @(negedge mdc);
    check("R10 bad start no pwrdn", pwrdn_o, 0);
    mgmt_rd(STRAP, 5'd0, d, r, dr);
    check("R10 frame after bad frame", {r, d}, {1'b1, 16'h0000});
  endtask

  task automatic t_soft();
    logic [15:0] d; logic r, dr;
    mgmt_wr(STRAP, 5'd0, 16'h8000);
    repeat (3) @(negedge mdc);
    check("R7 soft reset raises reset", chip_reset_o, 1);
    wait_reset_done();
    check("R7 soft window length", last_run, RST);
    mgmt_wr(STRAP, 5'd0, 16'h0000);
    check("R7 zero write no reset", chip_reset_o, 0);
    mgmt_wr_tight(STRAP, 5'd0, 16'h8000);
    mgmt_rd(STRAP, 5'd0, d, r, dr);
    check("R7 bit15 set during window", d, 16'h8000);
    wait_reset_done();
    mgmt_rd(STRAP, 5'd0, d, r, dr);
    check("R7 bit15 self-clears", d, 16'h0000);
  endtask

  task automatic t_collide();
    logic [15:0] d; logic r, dr;
    mgmt_wr_tight(STRAP, 5'd0, 16'h8000);
    mgmt_wr_tight(STRAP, 5'd0, 16'h8000);
    mdio_i = 1'b1;
    repeat (3) @(negedge mdc);
    check("R12 reset held after collision", chip_reset_o, 1);
    wait_reset_done();
    check("R12 window restarted unbroken", last_run, 2 * RST);
    mgmt_rd(STRAP, 5'd0, d, r, dr);
    check("R12 bit15 clear after restart", d, 16'h0000);
  endtask

  task automatic t_pin_reset();
    logic [15:0] d; logic r, dr;
    @(negedge mdc);
    rst_pin_n = 1'b0;
    repeat (5) @(negedge mdc);
    rst_pin_n = 1'b1;
    check("R8 pin reset raises reset", chip_reset_o, 1);
    wait_reset_done();
    check("R8 pin reset window", last_run, RST + 4);
    mgmt_rd(STRAP, 5'd0, d, r, dr);
    check("R8 R5 pin reset restores default", d, 16'h0400);
  endtask

  initial begin
    repeat (60000) @(posedge mdc);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    por = 1'b1; rst_pin_n = 1'b1; phy_addr_strap = STRAP;
    iso_default_strap = 1'b1; iso_pin = 1'b0; pwrdn_pin = 1'b0;
    aneg_strap = 1'b1; mdio_i = 1'b1;
    repeat (4) @(negedge mdc);
    por = 1'b0;
    @(negedge mdc);
    t_reset();
    t_addr();
    t_pins();
    t_pd_reg();
    t_unimpl();
    t_bad();
    t_soft();
    t_collide();
    t_pin_reset();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule